// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block works next to a small 16-bit processor core and takes over at instruction boundaries. When the core reports that an instruction has finished, the block looks at every pending interrupt cause, selects exactly one by a fixed ranking, and produces an 8-bit vector number. It then runs the real-mode entry steps on a 16-bit memory bus. It saves the flags, the code segment and the instruction pointer on the stack, writes back flags with the interrupt-enable and trap bits cleared, and fetches the new instruction pointer and code segment from the vector table in the lowest 1 KB of memory.

The core owns its registers. The block reads them on input ports and updates them through write strobes. It raises `busy` so the core stays stalled until the new code segment is loaded. A return request runs the opposite sequence: it pops the instruction pointer, then the code segment, then the flags. Maskable requests are acknowledged with a one-cycle `inta` pulse, and the vector number is taken from the low data-bus byte during that pulse. Software INT n, the one-byte breakpoint (the core passes vector 3) and the conditional overflow request (INTO) arrive as boundary-qualified inputs.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `inta`, `mem_req` and all register write strobes are 0.
- R2: At a boundary the block accepts one source in this rank order: divide error (vector 0), then single-step (vector 1), then NMI (vector 2), then maskable INTR, then software INT. Latched sources that lose (divide error, NMI, software INT) stay pending and are taken at later boundaries.
- R3: Entry writes the word for each push at physical address SS*16+SP after first subtracting 2 from SP. The order is flags, then CS, then IP, and the final SP is the starting SP minus 6.
- R4: The pushed flags word is the original flags value. The flags written back to the core have IF (bit 9) and TF (bit 8) cleared and all other bits unchanged.
- R5: For vector n, the new IP is the word at byte address 4n and the new CS is the word at byte address 4n+2.
- R6: INTR is taken only while IF (bit 9) is 1. When IF is 0, a pending INTR causes no bus cycle, no `inta` and no register change. An accepted INTR gives exactly one `inta` cycle, and the vector is the low byte of `mem_rdata` in that cycle.
- R7: A rising edge on `nmi` is latched and taken at the next boundary regardless of IF, using vector 2.
- R8: When TF (bit 8) is 1 at a boundary, entry uses vector 1. Because entry clears TF, the next boundary with no other cause produces no entry.
- R9: An overflow request enters with vector 4 only when OF (bit 11) is 1. When OF is 0 it has no effect: no `busy`, and SP and flags are unchanged.
- R10: Software INT n enters with the vector given on `sw_vec`, including vector 3 for the breakpoint.
- R11: A return request pops IP, then CS, then flags from SS*16+SP, adding 2 to SP after each pop, so SP ends 6 higher than it started.
- R12: `busy` is 1 from the cycle after acceptance until the cycle that loads CS (entry) or flags (return). It lasts exactly 5 cycles for a non-INTR entry with zero-wait memory and 6 cycles for an INTR entry. A memory request keeps its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_done | input | 1 | Instruction boundary strobe from the core |
| div_err | input | 1 | Finished instruction raised a divide error |
| sw_int | input | 1 | Finished instruction was INT n |
| sw_vec | input | 8 | Vector number for INT n |
| into_req | input | 1 | Finished instruction was INTO |
| iret_req | input | 1 | Start the return pop sequence |
| nmi | input | 1 | Non-maskable request (edge) |
| intr | input | 1 | Maskable request (level) |
| inta | output | 1 | Maskable request acknowledge |
| flags_i | input | 16 | Current flags |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| busy | output | 1 | Core stall |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data; low byte carries the vector during `inta` |
| mem_ack | input | 1 | Memory completion |
| flags_we | output | 1 | Flags write strobe |
| flags_wd | output | 16 | Flags write value |
| cs_we | output | 1 | CS write strobe |
| cs_wd | output | 16 | CS write value |
| ip_we | output | 1 | IP write strobe |
| ip_wd | output | 16 | IP write value |
| sp_we | output | 1 | SP write strobe |
| sp_wd | output | 16 | SP write value |

## Verification
Each kind of source is tried on its own: INT n, the breakpoint, INTO with OF set and clear, single-step, NMI with IF clear, and INTR with IF clear and then set. Each separate vector shows up as a separate IP/CS pair fetched from the table. One boundary with divide error, TF, NMI, INTR and INT all pending is followed by bare boundaries. This exposes the rank order, the loss of INTR once entry clears IF, and that losing latched sources are kept. An entry followed by a return proves that the pops mirror the pushes, and a run with wait-stated memory shows that the sequence holds its requests until they are acknowledged.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_INTA, ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP,
        ST_RD_IP, ST_RD_CS, ST_POP_IP, ST_POP_CS, ST_POP_F
    } seq_st_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_DIV, SRC_STEP, SRC_NMI, SRC_INTR, SRC_SW
    } src_e;

    localparam int VEC_DIVIDE = 0;
    localparam int VEC_STEP   = 1;
    localparam int VEC_NMI    = 2;
    localparam int VEC_OVF    = 4;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import irq_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done,
    input  logic             div_err,
    input  logic             sw_int,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic             into_req,
    input  logic             of_flag,
    input  logic             nmi,
    input  logic             take,
    input  src_e             src,
    output logic             div_eff,
    output logic             nmi_eff,
    output logic             sw_eff,
    output logic [VEC_W-1:0] sw_vec_eff
);
    typedef struct packed {
        logic             nmi_prev;
        logic             nmi_pend;
        logic             div_pend;
        logic             sw_pend;
        logic [VEC_W-1:0] sw_vec;
    } lat_t;

    lat_t q, d;
    logic sw_new, nmi_rise;
    logic [VEC_W-1:0] sw_new_vec;

    always_comb begin
        sw_new     = instr_done && (sw_int || (into_req && of_flag));
        sw_new_vec = sw_int ? sw_vec : VEC_W'(VEC_OVF);
        nmi_rise   = nmi && !q.nmi_prev;
        div_eff    = q.div_pend || (instr_done && div_err);
        nmi_eff    = q.nmi_pend;
        sw_eff     = q.sw_pend || sw_new;
        sw_vec_eff = sw_new ? sw_new_vec : q.sw_vec;

        d          = q;
        d.nmi_prev = nmi;
        d.div_pend = div_eff && !(take && src == SRC_DIV);
        d.nmi_pend = (q.nmi_pend && !(take && src == SRC_NMI)) || nmi_rise;
        d.sw_pend  = sw_eff && !(take && src == SRC_SW);
        d.sw_vec   = sw_vec_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    nmi_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |=> q.nmi_pend);

    // R2
    div_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.div_pend && !(take && src == SRC_DIV)) |=> q.div_pend);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_entry_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             boundary,
    input  logic             div_p,
    input  logic             step_p,
    input  logic             nmi_p,
    input  logic             intr_p,
    input  logic             if_flag,
    input  logic             sw_p,
    input  logic [VEC_W-1:0] sw_vec,
    output logic             take,
    output src_e             src,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        take = 1'b0;
        src  = SRC_NONE;
        vec  = '0;
        if (boundary) begin
            if (div_p) begin
                take = 1'b1; src = SRC_DIV;  vec = VEC_W'(VEC_DIVIDE);
            end else if (step_p) begin
                take = 1'b1; src = SRC_STEP; vec = VEC_W'(VEC_STEP);
            end else if (nmi_p) begin
                take = 1'b1; src = SRC_NMI;  vec = VEC_W'(VEC_NMI);
            end else if (intr_p && if_flag) begin
                take = 1'b1; src = SRC_INTR;
            end else if (sw_p) begin
                take = 1'b1; src = SRC_SW;   vec = sw_vec;
            end
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int VEC_W  = 8,
    parameter int IF_POS = 9,
    parameter int TF_POS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  src_e              src,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              iret_req,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [DATA_W-1:0] cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [DATA_W-1:0] ss_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic              busy,
    output logic              inta,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              flags_we,
    output logic [DATA_W-1:0] flags_wd,
    output logic              cs_we,
    output logic [DATA_W-1:0] cs_wd,
    output logic              ip_we,
    output logic [DATA_W-1:0] ip_wd,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wd
);
    localparam int SEG_SH = ADDR_W - DATA_W;
    localparam int PAD_W  = ADDR_W - VEC_W - 2;
    localparam logic [DATA_W-1:0] CLR_MASK =
        (DATA_W'(1) << IF_POS) | (DATA_W'(1) << TF_POS);
    localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);

    typedef struct packed {
        seq_st_e           st;
        logic [VEC_W-1:0]  vec;
        logic [DATA_W-1:0] flg;
        logic [DATA_W-1:0] cs;
        logic [DATA_W-1:0] ip;
        logic [DATA_W-1:0] ss;
        logic [DATA_W-1:0] sp;
    } seq_t;

    seq_t q, d;
    logic [ADDR_W-1:0] stk_addr, vip_addr, vcs_addr;

    always_comb begin
        stk_addr = ({{SEG_SH{1'b0}}, q.ss} << SEG_SH) + {{SEG_SH{1'b0}}, q.sp};
        vip_addr = {{PAD_W{1'b0}}, q.vec, 2'b00};
        vcs_addr = {{PAD_W{1'b0}}, q.vec, 2'b10};
    end

    always_comb begin
        d         = q;
        inta      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        flags_we  = 1'b0;
        flags_wd  = q.flg;
        cs_we     = 1'b0;
        cs_wd     = mem_rdata;
        ip_we     = 1'b0;
        ip_wd     = mem_rdata;
        sp_we     = 1'b0;
        sp_wd     = q.sp;
        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.vec = vec_i;
                    d.flg = flags_i;
                    d.cs  = cs_i;
                    d.ip  = ip_i;
                    d.ss  = ss_i;
                    d.sp  = sp_i - WORD_STEP;
                    d.st  = (src == SRC_INTR) ? ST_INTA : ST_PUSH_F;
                end else if (iret_req) begin
                    d.ss = ss_i;
                    d.sp = sp_i;
                    d.st = ST_POP_IP;
                end
            end
            ST_INTA: begin
                inta  = 1'b1;
                d.vec = mem_rdata[VEC_W-1:0];
                d.st  = ST_PUSH_F;
            end
            ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stk_addr;
                mem_wdata = (q.st == ST_PUSH_F)  ? q.flg :
                            (q.st == ST_PUSH_CS) ? q.cs  : q.ip;
                if (mem_ack) begin
                    sp_we = 1'b1;
                    if (q.st == ST_PUSH_F) begin
                        flags_we = 1'b1;
                        flags_wd = q.flg & ~CLR_MASK;
                        d.sp     = q.sp - WORD_STEP;
                        d.st     = ST_PUSH_CS;
                    end else if (q.st == ST_PUSH_CS) begin
                        d.sp = q.sp - WORD_STEP;
                        d.st = ST_PUSH_IP;
                    end else begin
                        d.st = ST_RD_IP;
                    end
                end
            end
            ST_RD_IP: begin
                mem_req  = 1'b1;
                mem_addr = vip_addr;
                if (mem_ack) begin
                    ip_we = 1'b1;
                    d.st  = ST_RD_CS;
                end
            end
            ST_RD_CS: begin
                mem_req  = 1'b1;
                mem_addr = vcs_addr;
                if (mem_ack) begin
                    cs_we = 1'b1;
                    d.st  = ST_IDLE;
                end
            end
            ST_POP_IP, ST_POP_CS, ST_POP_F: begin
                mem_req  = 1'b1;
                mem_addr = stk_addr;
                if (mem_ack) begin
                    sp_we = 1'b1;
                    sp_wd = q.sp + WORD_STEP;
                    d.sp  = q.sp + WORD_STEP;
                    if (q.st == ST_POP_IP) begin
                        ip_we = 1'b1;
                        d.st  = ST_POP_CS;
                    end else if (q.st == ST_POP_CS) begin
                        cs_we = 1'b1;
                        d.st  = ST_POP_F;
                    end else begin
                        flags_we = 1'b1;
                        flags_wd = mem_rdata;
                        d.st     = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.st != ST_IDLE);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cs_we) || $past(flags_we)));

    // R6
    inta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> (!inta && busy));

    // R3
    one_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_we, cs_we, ip_we}));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int VEC_W  = 8,
    parameter int IF_POS = 9,
    parameter int TF_POS = 8,
    parameter int OF_POS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              div_err,
    input  logic              sw_int,
    input  logic [VEC_W-1:0]  sw_vec,
    input  logic              into_req,
    input  logic              iret_req,
    input  logic              nmi,
    input  logic              intr,
    output logic              inta,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [DATA_W-1:0] cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [DATA_W-1:0] ss_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              flags_we,
    output logic [DATA_W-1:0] flags_wd,
    output logic              cs_we,
    output logic [DATA_W-1:0] cs_wd,
    output logic              ip_we,
    output logic [DATA_W-1:0] ip_wd,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wd
);
    logic             take, div_p, nmi_p, sw_p;
    logic [VEC_W-1:0] sw_pvec, sel_vec;
    src_e             src;

    irq_src_latch #(.VEC_W(VEC_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
        .div_err(div_err), .sw_int(sw_int), .sw_vec(sw_vec),
        .into_req(into_req), .of_flag(flags_i[OF_POS]), .nmi(nmi),
        .take(take), .src(src), .div_eff(div_p), .nmi_eff(nmi_p),
        .sw_eff(sw_p), .sw_vec_eff(sw_pvec)
    );

    irq_prio_sel #(.VEC_W(VEC_W)) u_prio (
        .boundary(instr_done && !busy), .div_p(div_p),
        .step_p(flags_i[TF_POS]), .nmi_p(nmi_p), .intr_p(intr),
        .if_flag(flags_i[IF_POS]), .sw_p(sw_p), .sw_vec(sw_pvec),
        .take(take), .src(src), .vec(sel_vec)
    );

    irq_seq_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
        .IF_POS(IF_POS), .TF_POS(TF_POS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .take(take), .src(src), .vec_i(sel_vec),
        .iret_req(iret_req), .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i),
        .ss_i(ss_i), .sp_i(sp_i), .busy(busy), .inta(inta),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .flags_we(flags_we), .flags_wd(flags_wd), .cs_we(cs_we),
        .cs_wd(cs_wd), .ip_we(ip_we), .ip_wd(ip_wd), .sp_we(sp_we),
        .sp_wd(sp_wd)
    );

    // R6
    inta_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |-> $past(flags_i[IF_POS]));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 0, div_err = 0, sw_int = 0, into_req = 0;
    logic        iret_req = 0, nmi = 0, intr = 0;
    logic [7:0]  sw_vec = 8'h00;
    logic        inta, busy, mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        flags_we, cs_we, ip_we, sp_we;
    logic [15:0] flags_wd, cs_wd, ip_wd, sp_wd;

    logic [15:0] r_flags, r_cs, r_ip, r_sp;
    logic [15:0] ss_val = 16'h0000;
    logic        set_en = 0;
    logic [15:0] s_flags = 0, s_cs = 0, s_ip = 0, s_sp = 0;
    logic [15:0] stk [0:2047];
    logic        slow = 0, wt;
    logic [7:0]  ivec = 8'h40;
    int          inta_cnt = 0;
    int          tests = 0, fails = 0, last_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .div_err(div_err),
        .sw_int(sw_int), .sw_vec(sw_vec), .into_req(into_req),
        .iret_req(iret_req), .nmi(nmi), .intr(intr), .inta(inta),
        .flags_i(r_flags), .cs_i(r_cs), .ip_i(r_ip), .ss_i(ss_val), .sp_i(r_sp),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .flags_we(flags_we), .flags_wd(flags_wd), .cs_we(cs_we), .cs_wd(cs_wd),
        .ip_we(ip_we), .ip_wd(ip_wd), .sp_we(sp_we), .sp_wd(sp_wd)
    );

    // vector table: entry n holds IP 1000h+n and CS 2000h+n
    always_comb begin
        if (inta)
            mem_rdata = {8'h00, ivec};
        else if (mem_addr < 20'h400)
            mem_rdata = mem_addr[1] ? (16'h2000 + {8'h00, mem_addr[9:2]})
                                    : (16'h1000 + {8'h00, mem_addr[9:2]});
        else
            mem_rdata = stk[mem_addr[11:1]];
        mem_ack = mem_req && (!slow || wt);
    end

    always @(posedge clk) begin
        if (!rst_n) wt <= 1'b0;
        else        wt <= mem_req ? !wt : 1'b0;
        if (mem_req && mem_we && mem_ack) stk[mem_addr[11:1]] <= mem_wdata;
        if (inta) inta_cnt <= inta_cnt + 1;
        if (set_en) begin
            r_flags <= s_flags; r_cs <= s_cs; r_ip <= s_ip; r_sp <= s_sp;
        end else begin
            if (flags_we) r_flags <= flags_wd;
            if (cs_we)    r_cs    <= cs_wd;
            if (ip_we)    r_ip    <= ip_wd;
            if (sp_we)    r_sp    <= sp_wd;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_regs(input logic [15:0] f, cs, ip, sp);
        @(negedge clk);
        set_en = 1; s_flags = f; s_cs = cs; s_ip = ip; s_sp = sp;
        @(negedge clk);
        set_en = 0;
    endtask

    task automatic wait_idle();
        last_busy = 0;
        while (busy && last_busy < 200) begin
            last_busy++;
            @(negedge clk);
        end
    endtask

    task automatic boundary(input logic dv, sw, input logic [7:0] v, input logic io);
        @(negedge clk);
        instr_done = 1; div_err = dv; sw_int = sw; sw_vec = v; into_req = io;
        @(negedge clk);
        instr_done = 0; div_err = 0; sw_int = 0; into_req = 0;
        wait_idle();
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi = 1;
        @(negedge clk); nmi = 0;
    endtask

    // boundary expected to enter through vector n; checks stack and registers
    task automatic entry(input string tag, input logic dv, sw,
                         input logic [7:0] v, input logic io, input logic [7:0] n);
        logic [15:0] f0, c0, i0, s0;
        f0 = r_flags; c0 = r_cs; i0 = r_ip; s0 = r_sp;
        boundary(dv, sw, v, io);
        chk({tag, " R5 ip"}, r_ip, 16'h1000 + {8'h00, n});
        chk({tag, " R5 cs"}, r_cs, 16'h2000 + {8'h00, n});
        chk({tag, " R3 sp"}, r_sp, s0 - 16'd6);
        chk({tag, " R4 flags"}, r_flags, f0 & ~16'h0300);
        chk({tag, " R3 R4 pushed flags"}, stk[(s0 - 16'd2) >> 1], f0);
        chk({tag, " R3 pushed cs"}, stk[(s0 - 16'd4) >> 1], c0);
        chk({tag, " R3 pushed ip"}, stk[(s0 - 16'd6) >> 1], i0);
    endtask

    task automatic no_entry(input string tag, input logic io);
        logic [15:0] f0, s0;
        int          a0;
        f0 = r_flags; s0 = r_sp; a0 = inta_cnt;
        boundary(0, 0, 8'h00, io);
        chk({tag, " busy"}, last_busy, 0);
        chk({tag, " sp"}, r_sp, s0);
        chk({tag, " flags"}, r_flags, f0);
        chk({tag, " inta"}, inta_cnt, a0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 inta", inta, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 strobes", {flags_we, cs_we, ip_we, sp_we}, 0);
    endtask

    task automatic t_swint();
        set_regs(16'h0200, 16'h1234, 16'h0056, 16'h0800);
        entry("R10 int21", 0, 1, 8'h21, 0, 8'h21);
        chk("R12 busy cycles sw", last_busy, 5);
        set_regs(16'h0001, 16'h4321, 16'h0099, 16'h0700);
        entry("R10 int3", 0, 1, 8'h03, 0, 8'h03);
    endtask

    task automatic t_into();
        set_regs(16'h0200, 16'h1111, 16'h0010, 16'h0800);
        no_entry("R9 into of=0", 1);
        set_regs(16'h0A00, 16'h1111, 16'h0010, 16'h0800);
        entry("R9 into of=1", 0, 0, 8'h00, 1, 8'h04);
    endtask

    task automatic t_step();
        set_regs(16'h0100, 16'h3000, 16'h0020, 16'h0800);
        entry("R8 step", 0, 0, 8'h00, 0, 8'h01);
        no_entry("R8 no re-trap", 0);
    endtask

    task automatic t_intr();
        int a0;
        set_regs(16'h0000, 16'h5000, 16'h0030, 16'h0800);
        intr = 1;
        no_entry("R6 masked intr", 0);
        set_regs(16'h0200, 16'h5000, 16'h0030, 16'h0800);
        a0 = inta_cnt;
        entry("R6 intr", 0, 0, 8'h00, 0, 8'h40);
        chk("R6 inta count", inta_cnt, a0 + 1);
        chk("R12 busy cycles intr", last_busy, 6);
        intr = 0;
    endtask

    task automatic t_nmi();
        set_regs(16'h0000, 16'h6000, 16'h0040, 16'h0800);
        pulse_nmi();
        entry("R7 nmi", 0, 0, 8'h00, 0, 8'h02);
    endtask

    task automatic t_prio();
        set_regs(16'h0300, 16'h7000, 16'h0050, 16'h0800);
        pulse_nmi();
        intr = 1;
        entry("R2 div first", 1, 1, 8'h21, 0, 8'h00);
        entry("R2 nmi kept", 0, 0, 8'h00, 0, 8'h02);
        entry("R2 sw kept", 0, 0, 8'h00, 0, 8'h21);
        set_regs(16'h0200, r_cs, r_ip, r_sp);
        entry("R2 intr last", 0, 0, 8'h00, 0, 8'h40);
        intr = 0;
        no_entry("R2 all drained", 0);
    endtask

    task automatic t_iret();
        set_regs(16'h0A55, 16'h8123, 16'h0456, 16'h0800);
        entry("R11 pre", 0, 1, 8'h30, 0, 8'h30);
        @(negedge clk); iret_req = 1;
        @(negedge clk); iret_req = 0;
        wait_idle();
        chk("R11 ip", r_ip, 16'h0456);
        chk("R11 cs", r_cs, 16'h8123);
        chk("R11 flags", r_flags, 16'h0A55);
        chk("R11 sp", r_sp, 16'h0800);
    endtask

    task automatic t_slow();
        slow = 1;
        set_regs(16'h0200, 16'h9000, 16'h0060, 16'h0800);
        entry("R12 slow", 0, 1, 8'h55, 0, 8'h55);
        chk("R12 slow busy longer", last_busy > 5, 1);
        slow = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_swint();
        t_into();
        t_step();
        t_intr();
        t_nmi();
        t_prio();
        t_iret();
        t_slow();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule